// File: doc/BRIEF.md
# Serial EEPROM Write-Protect and Bulk-Operation Controller

This block is the control core of a three-wire serial EEPROM slave. A host selects it with a chip-select line and shifts instruction frames in on a serial data line, one bit per rising edge of a serial clock. The core keeps a write-enable latch that guards every modifying operation. It handles the enable, disable, clear-all and write-all instructions, plus a single-location read so stored contents can be observed. Bulk operations are only armed by their frame. They start when chip select falls, and then run for a fixed number of system clocks with no serial clock.

All three host inputs cross into the system clock domain through two-flop synchronisers, and edges are found on the synchronised copies. The data output reports busy (low) or ready (high) whenever the device is selected and no read data is being shifted out. The memory is a plain register array of `2**ADDR_W` words of `WIDTH` bits, cleared by reset.

Top module: `mw_wp_ctrl`

## Requirements
- R1: After reset the write-enable latch is clear, no cycle is in progress, every memory word is zero, and the data output is high.
- R2: A frame is leading zeros, a start bit of 1, a 2-bit opcode sent MSB first, then an ADDR_W-bit address sent MSB first. With opcode 00 the top two address bits choose the instruction: 11 enable, 00 disable, 10 clear-all, 01 write-all.
- R3: The enable instruction sets the latch. It stays set through any other traffic until a disable instruction or a reset.
- R4: While the latch is clear, clear-all and write-all frames start no cycle and leave every memory word unchanged.
- R5: Opcode 10 reads the addressed word. Its MSB is on the data output once the last address bit has been taken. Each further serial-clock rise presents the next bit. This works whatever the latch state.
- R6: An accepted bulk frame does nothing while chip select stays high. The cycle starts only on the chip-select falling edge.
- R7: Clear-all sets every memory bit to 1. Write-all takes WIDTH data bits, MSB first, after the address and stores them in every word, with no prior clear needed.
- R8: While selected, the data output is low during a cycle and high when idle. A cycle lasts BUSY_CYC system clocks with no serial clock activity.
- R9: A selection that begins while a cycle is running is ignored as a whole, including enable and disable frames.
- R10: A selection that begins fewer than CS_MIN system clocks after the previous deselection is ignored as a whole.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| csel | input | 1 | Chip select, active high, asynchronous |
| sclk | input | 1 | Serial clock from host, asynchronous |
| sdi | input | 1 | Serial data in, sampled on sclk rise |
| sdo | output | 1 | Serial data out: read data or ready/busy status |

## Verification
Each input passes two synchroniser flops and one edge flop, so a serial-clock rise takes effect three to four system clocks after the pin moves. The bench holds every serial-clock level for four system clocks and samples read data only after the following low phase has ended. A busy cycle begins one clock after the chip-select fall is detected. The bench therefore checks for low status after a full deselect gap plus four select clocks, and it polls for ready, checking that the number of busy samples fits the BUSY_CYC window. Memory contents are checked only through read frames that start after the cycle has ended.

// File: rtl/mw_wp_ctrl.sv
module mw_wp_ctrl #(
  parameter int ADDR_W   = 6,
  parameter int WIDTH    = 8,
  parameter int BUSY_CYC = 200,
  parameter int CS_MIN   = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csel,
  input  logic sclk,
  input  logic sdi,
  output logic sdo
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HDR   = 2 + ADDR_W;
  localparam int FULL  = HDR + WIDTH;
  localparam int BCW   = $clog2(FULL + 1);
  localparam int GW    = $clog2(CS_MIN + 1);
  localparam int TW    = $clog2(BUSY_CYC + 1);

  typedef enum logic [1:0] {P_NONE, P_CLR, P_WR} pend_t;

  logic [2:0] cs_q, sk_q;
  logic [1:0] di_q;
  logic sel_ok, started, fdone, is_wral, wen, rd_act, busy;
  logic [BCW-1:0] bcnt;
  logic [FULL-1:0] sr;
  logic [WIDTH-1:0] wdata, rd_sr;
  logic [GW-1:0] gcnt;
  logic [TW-1:0] tcnt;
  pend_t pend, wop;
  logic [DEPTH-1:0][WIDTH-1:0] mem;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= '0; sk_q <= '0; di_q <= '0;
    end else begin
      cs_q <= {cs_q[1:0], csel};
      sk_q <= {sk_q[1:0], sclk};
      di_q <= {di_q[0], sdi};
    end

  wire cs_s    = cs_q[1];
  wire cs_rise = cs_q[1] & ~cs_q[2];
  wire cs_fall = ~cs_q[1] & cs_q[2];
  wire sk_rise = sk_q[1] & ~sk_q[2];
  wire bit_in  = di_q[1];

  wire [HDR-1:0]    hdr_next  = {sr[HDR-2:0], bit_in};
  wire [WIDTH-1:0]  data_next = {sr[WIDTH-2:0], bit_in};
  wire [1:0]        op        = hdr_next[HDR-1:HDR-2];
  wire [1:0]        sub       = hdr_next[ADDR_W-1:ADDR_W-2];
  wire [ADDR_W-1:0] addr      = hdr_next[ADDR_W-1:0];
  wire              done_cyc  = busy && (tcnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_ok <= 1'b0; started <= 1'b0; fdone <= 1'b0; is_wral <= 1'b0;
      wen <= 1'b0; rd_act <= 1'b0; busy <= 1'b0;
      bcnt <= '0; sr <= '0; wdata <= '0; rd_sr <= '0;
      gcnt <= '0; tcnt <= '0; pend <= P_NONE; wop <= P_NONE;
    end else begin
      if (gcnt != '0) gcnt <= gcnt - 1'b1;
      if (cs_rise) begin
        sel_ok  <= (gcnt == '0) && !busy;
        started <= 1'b0;
        fdone   <= 1'b0;
        is_wral <= 1'b0;
        bcnt    <= '0;
        rd_act  <= 1'b0;
      end else if (cs_fall) begin
        sel_ok <= 1'b0;
        rd_act <= 1'b0;
        gcnt   <= GW'(CS_MIN);
        pend   <= P_NONE;
        if (pend != P_NONE) begin
          busy <= 1'b1;
          tcnt <= TW'(BUSY_CYC - 1);
          wop  <= pend;
        end
      end else if (cs_s && sel_ok && sk_rise) begin
        if (rd_act) rd_sr <= {rd_sr[WIDTH-2:0], 1'b1};
        if (!started) started <= bit_in;
        else if (!fdone) begin
          sr   <= {sr[FULL-2:0], bit_in};
          bcnt <= bcnt + 1'b1;
          if (!is_wral && bcnt == BCW'(HDR - 1)) begin
            fdone <= 1'b1;
            if (op == 2'b10) begin
              rd_act <= 1'b1;
              rd_sr  <= mem[addr];
            end else if (op == 2'b00) begin
              case (sub)
                2'b11: wen <= 1'b1;
                2'b00: wen <= 1'b0;
                2'b10: if (wen) pend <= P_CLR;
                default: begin is_wral <= 1'b1; fdone <= 1'b0; end
              endcase
            end
          end else if (is_wral && bcnt == BCW'(FULL - 1)) begin
            fdone <= 1'b1;
            if (wen) begin
              pend  <= P_WR;
              wdata <= data_next;
            end
          end
        end
      end
      if (busy) begin
        if (tcnt == '0) busy <= 1'b0;
        else tcnt <= tcnt - 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mem <= '0;
    else if (done_cyc)
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (wop == P_CLR) ? {WIDTH{1'b1}} : wdata;

  assign sdo = !cs_s ? 1'b1 : busy ? 1'b0 : rd_act ? rd_sr[WIDTH-1] : 1'b1;

  AST_MEM_ONLY_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(mem)); // R4
  AST_CYCLE_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen); // R4
  AST_START_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cs_s)); // R6
  AST_NO_FRAME_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok |-> !busy); // R9
  AST_WEN_HELD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> $stable(wen)); // R3
endmodule

// File: tb/mw_wp_ctrl_test.sv
module mw_wp_ctrl_test;
  localparam int AW = 6, W = 8, BC = 200, CM = 25;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, csel = 0, sclk = 0, sdi = 0;
  logic sdo;
  int errs = 0, checks = 0;
  bit finished = 0;

  mw_wp_ctrl #(.ADDR_W(AW), .WIDTH(W), .BUSY_CYC(BC), .CS_MIN(CM)) uut (
    .clk(clk), .rst_n(rst_n), .csel(csel), .sclk(sclk), .sdi(sdi), .sdo(sdo));

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    @(negedge clk) sdi = b;
    repeat (4) @(negedge clk);
    sclk = 1;
    repeat (4) @(negedge clk);
    sclk = 0;
  endtask

  task automatic sel();
    @(negedge clk) csel = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel(input int gap = CM + 6);
    @(negedge clk) begin csel = 0; sdi = 0; end
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a);
    pulse(0);
    pulse(1);
    pulse(op[1]); pulse(op[0]);
    for (int i = AW - 1; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic ctrl(input logic [1:0] sub);
    sel();
    send_hdr(2'b00, {sub, {(AW-2){1'b0}}});
    desel();
  endtask

  task automatic bulk(input logic [1:0] sub, input logic [W-1:0] d);
    sel();
    send_hdr(2'b00, {sub, {(AW-2){1'b0}}});
    if (sub == 2'b01) for (int i = W - 1; i >= 0; i--) pulse(d[i]);
    desel();
  endtask

  task automatic read(input logic [AW-1:0] a, output logic [W-1:0] d);
    sel();
    send_hdr(2'b10, a);
    for (int i = W - 1; i >= 0; i--) begin
      d[i] = sdo;
      pulse(0);
    end
    desel();
  endtask

  task automatic wait_ready(input string req, input bit exp_busy);
    int n = 0;
    sel();
    check({req, " status on select"}, sdo, exp_busy ? 0 : 1);
    while (sdo == 0 && n < BC + 50) begin
      @(negedge clk);
      n++;
    end
    if (exp_busy) begin
      check({req, " R8 busy ends"}, sdo, 1);
      check({req, " R8 busy window"}, (n > BC - 60 && n <= BC) ? 1 : 0, 1);
    end
    desel();
  endtask

  task automatic check_mem(input string req, input logic [W-1:0] exp);
    logic [W-1:0] d;
    for (int a = 0; a < DEPTH; a += 7) begin
      read(a[AW-1:0], d);
      check({req, " word"}, d, exp);
    end
    read(AW'(DEPTH - 1), d);
    check({req, " last word"}, d, exp);
  endtask

  task automatic t_reset();
    @(negedge clk) check("R1 sdo idle after reset", sdo, 1);
    sel();
    check("R1 R8 ready when selected", sdo, 1);
    desel();
    check_mem("R1 R5 zero after reset", 8'h00);
    bulk(2'b01, 8'hA5);
    wait_ready("R4 write-all without enable", 0);
    bulk(2'b10, 8'h00);
    wait_ready("R4 clear-all without enable", 0);
    check_mem("R4 memory untouched", 8'h00);
  endtask

  task automatic t_enable_clear();
    ctrl(2'b11);
    check_mem("R3 R5 reads with latch set", 8'h00);
    bulk(2'b10, 8'h00);
    wait_ready("R2 R3 clear-all runs", 1);
    check_mem("R7 clear-all gives ones", 8'hFF);
  endtask

  task automatic t_write_all();
    bulk(2'b01, 8'h3C);
    wait_ready("R7 write-all runs", 1);
    check_mem("R7 write-all no prior clear", 8'h3C);
  endtask

  task automatic t_cs_held();
    sel();
    send_hdr(2'b00, {2'b01, {(AW-2){1'b0}}});
    for (int i = W - 1; i >= 0; i--) pulse(8'h81 >> i);
    repeat (BC + 100) @(negedge clk);
    check("R6 no cycle while still selected", sdo, 1);
    desel();
    wait_ready("R6 cycle after deselect", 1);
    check_mem("R6 write-all data", 8'h81);
  endtask

  task automatic t_busy_ignore();
    bulk(2'b01, 8'h55);
    sel();
    check("R8 R9 busy while reselected", sdo, 0);
    send_hdr(2'b00, {2'b00, {(AW-2){1'b0}}});
    desel();
    sel();
    while (sdo == 0) @(negedge clk);
    desel();
    check_mem("R9 cycle result", 8'h55);
    bulk(2'b10, 8'h00);
    wait_ready("R9 disable during cycle ignored", 1);
    check_mem("R9 clear-all after ignored disable", 8'hFF);
  endtask

  task automatic t_disable();
    ctrl(2'b00);
    bulk(2'b01, 8'h00);
    wait_ready("R2 R4 write-all after disable", 0);
    check_mem("R4 R5 memory kept, reads work", 8'hFF);
  endtask

  task automatic t_gap();
    logic [W-1:0] d;
    ctrl(2'b11);
    sel();
    send_hdr(2'b10, '0);
    desel(5);
    sel();
    send_hdr(2'b00, {2'b00, {(AW-2){1'b0}}});
    desel();
    bulk(2'b01, 8'h99);
    wait_ready("R10 early reselect ignored", 1);
    check_mem("R10 latch still set", 8'h99);
    read(AW'(3), d);
    check("R5 single read", d, 8'h99);
  endtask

  task automatic t_reset_clears();
    @(negedge clk) rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    bulk(2'b10, 8'h00);
    wait_ready("R1 R3 latch cleared by reset", 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_enable_clear();
    t_write_all();
    t_cs_held();
    t_busy_ignore();
    t_disable();
    t_gap();
    t_reset_clears();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule